// File: doc/BRIEF.md
# I2C Interrupt Status Aggregator

This block collects the event sources of an I2C controller into one interrupt line. Sticky event pulses and two level-type conditions form a 13-bit raw status vector. An active-low mask register (a 0 blocks, a 1 passes) selects which raw bits reach the masked status vector. The OR of the masked vector drives an active-high interrupt output. A separate 32-bit transmit-abort cause register records why a transfer was aborted. Any abort event also produces a one-cycle flush pulse for the transmit FIFO level counter.

The host reaches the block through a simple register port with read and write strobes. Read data appears one cycle after the read strobe. Status bits are cleared as a side effect of reading: each clearable interrupt has its own clear address, and one combined address clears every clearable bit together with the abort-cause register. Cause bit 9 records a start byte that was sent while restart was disabled. If that condition still holds when bit 9 is cleared, the bit drops for one cycle and then comes back.

Top module: `i2c_irq_agg`

## Requirements
- R1: After reset, the raw vector, the masked vector, the mask register and the abort-cause register are all zero, and `irq_o` is low.
- R2: A pulse on `evt_pulse_i[b]` sets sticky raw bit b on the next clock edge. The bit then stays set until a clear read for it. The sticky bits are 0 rx_under, 1 rx_over, 3 tx_over, 5 rd_req, 6 tx_abrt, 7 rx_done, 8 activity, 9 stop, 10 start, 11 gen_call and 12 restart.
- R3: Raw bit 2 follows `evt_level_i[0]` and raw bit 4 follows `evt_level_i[1]` with no register in the path. Pulses on `evt_pulse_i[2]` and `evt_pulse_i[4]` have no effect. Reads of the clear addresses 18 and 20 return 0 and change nothing.
- R4: `masked_stat_o` equals raw AND mask, so a mask bit of 1 passes its bit and a 0 blocks it. `irq_o` is high exactly when any masked bit is 1.
- R5: The raw vector does not depend on the mask.
- R6: A read of address 16+b, for sticky b, clears only raw bit b. The read data carries the pre-clear value of that bit in bit 0.
- R7: A read of address 4 clears all sticky raw bits and the abort-cause register, with the bit 9 rule below. The read data is the sticky part of the raw vector as it was before the clear.
- R8: If a set pulse and a clear read hit the same bit in the same cycle, the bit ends up set.
- R9: A nonzero `abrt_set_i`, or `evt_pulse_i[6]`, sets raw bit 6. `abrt_set_i` bits are ORed into the cause register, which is readable at address 3. A read of address 22 or address 4 clears the cause register.
- R10: When cause bit 9 is cleared while its condition holds, the bit reads 0 in the cycle after the clear and 1 from the following cycle onward.
- R11: The bit 9 condition is absent, and the bit stays clear after a clear read, when `restart_en_i` is 1, or `tar_special_i` is 0, or `tar_gc_start_i` is 0.
- R12: `tx_flush_o` is high for exactly the one cycle in which raw bit 6 first shows an abort event.
- R13: A write to address 1 loads the mask from `reg_wdata_i[12:0]`. Address 0 reads the raw vector, address 1 the mask and address 2 the masked vector. Read data is valid in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse_i | input | 13 | One-cycle set pulses for the sticky raw bits |
| evt_level_i | input | 2 | Level conditions for raw bits 2 and 4 |
| abrt_set_i | input | 32 | One-cycle abort-cause set pulses |
| restart_en_i | input | 1 | Restart is enabled in the controller |
| tar_special_i | input | 1 | Target special-command flag |
| tar_gc_start_i | input | 1 | Target general-call / start-byte select |
| reg_rd_i | input | 1 | Host read strobe |
| reg_wr_i | input | 1 | Host write strobe |
| reg_addr_i | input | 5 | Host word address |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Host read data, one cycle after the strobe |
| raw_stat_o | output | 13 | Raw status vector |
| masked_stat_o | output | 13 | Masked status vector |
| irq_o | output | 1 | Interrupt, active high |
| tx_flush_o | output | 1 | Pulse that clears the transmit FIFO level |

## Verification
The hardest behaviour to reach is the one-cycle dip of cause bit 9. It is visible only if the cause register is read back in the single cycle that follows the clear. The bench therefore issues a clear read and then two cause-register reads on back-to-back cycles. The first cause read must show 0 and the second must show bit 9 set again. It then repeats the sequence three times, once with each of the three conditions removed, and checks that both reads stay 0. The same-cycle race between a set pulse and a clear read is forced by driving both in one cycle.

// File: rtl/i2c_irq_pkg.sv
// Shared constants for the I2C interrupt aggregator: bit positions of the
// raw status vector, which bits are level-driven, and the host word map.
package i2c_irq_pkg;

    localparam int NIRQ = 13;

    localparam int IRQ_RX_UNDER = 0;
    localparam int IRQ_RX_OVER  = 1;
    localparam int IRQ_RX_FULL  = 2;
    localparam int IRQ_TX_OVER  = 3;
    localparam int IRQ_TX_EMPTY = 4;
    localparam int IRQ_RD_REQ   = 5;
    localparam int IRQ_TX_ABRT  = 6;
    localparam int IRQ_RX_DONE  = 7;
    localparam int IRQ_ACTIVITY = 8;
    localparam int IRQ_STOP     = 9;
    localparam int IRQ_START    = 10;
    localparam int IRQ_GEN_CALL = 11;
    localparam int IRQ_RESTART  = 12;

    localparam logic [NIRQ-1:0] LEVEL_BITS =
        (NIRQ'(1) << IRQ_RX_FULL) | (NIRQ'(1) << IRQ_TX_EMPTY);
    localparam logic [NIRQ-1:0] STICKY_BITS = ~LEVEL_BITS;

    localparam int CAUSE_SBYTE_NORST = 9;

    localparam int ADR_RAW      = 0;
    localparam int ADR_MASK     = 1;
    localparam int ADR_MASKED   = 2;
    localparam int ADR_CAUSE    = 3;
    localparam int ADR_CLR_ALL  = 4;
    localparam int ADR_CLR_BASE = 16;

endpackage

// File: rtl/i2c_irq_status_bank.sv
// Raw status bank. Each level-type position is a wire from its level input.
// Each other position is a sticky flop that a set pulse raises and a clear
// strobe lowers. Set takes priority over clear.
// Assumes set and clear strobes are one clock wide and synchronous to clk.
module i2c_irq_status_bank
    import i2c_irq_pkg::*;
#(
    parameter int              N     = NIRQ,
    parameter logic [N-1:0]    LEVEL = LEVEL_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] level_i,
    output logic [N-1:0] raw_o
);

    logic unused_bits;
    assign unused_bits = ^(set_i & LEVEL) ^ ^(clr_i & LEVEL) ^ ^(level_i & ~LEVEL);

    for (genvar b = 0; b < N; b++) begin : g_bit
        if (LEVEL[b]) begin : g_lvl
            // pass the level condition straight through
            assign raw_o[b] = level_i[b];
        end else begin : g_stk
            logic q;
            // sticky flag: set wins over clear
            always_ff @(posedge clk) begin
                if (!rst_n)        q <= 1'b0;
                else if (set_i[b]) q <= 1'b1;
                else if (clr_i[b]) q <= 1'b0;
            end
            assign raw_o[b] = q;
        end
    end

endmodule

// File: rtl/i2c_irq_abort_cause.sv
// Transmit-abort cause register. Set pulses are ORed in, and a clear strobe
// zeroes the register. Bit HOLD_BIT is re-set one cycle after a clear if its
// condition is present both at the clear and in the following cycle.
// Assumes the condition input is a level from the controller configuration.
module i2c_irq_abort_cause #(
    parameter int W        = 32,
    parameter int HOLD_BIT = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    input  logic         hold_cause_i,
    output logic [W-1:0] cause_o
);

    logic [W-1:0] cause_q;
    logic [W-1:0] cause_d;
    logic         reassert_q;

    // next cause value: clear, re-set of the held bit, then new pulses on top
    always_comb begin
        cause_d = clr_i ? '0 : cause_q;
        if (reassert_q && hold_cause_i) cause_d[HOLD_BIT] = 1'b1;
        cause_d = cause_d | set_i;
    end

    // cause storage and the one-cycle re-assert marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q    <= '0;
            reassert_q <= 1'b0;
        end else begin
            cause_q    <= cause_d;
            reassert_q <= clr_i & hold_cause_i;
        end
    end

    assign cause_o = cause_q;

endmodule

// File: rtl/i2c_irq_host_port.sv
// Host register port: holds the active-low mask, decodes the read-to-clear
// addresses into clear strobes, and registers the read data. Read data
// captures pre-clear values on the same edge that applies the clear.
// Assumes single-cycle read and write strobes that never overlap.
module i2c_irq_host_port
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 32,
    parameter int N       = NIRQ,
    parameter int CAUSE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_i,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [N-1:0]       raw_i,
    input  logic [CAUSE_W-1:0] cause_i,
    output logic [N-1:0]       mask_o,
    output logic [N-1:0]       clr_bits_o,
    output logic               clr_cause_o,
    output logic [DATA_W-1:0]  rdata_o
);

    logic [N-1:0]      mask_q;
    logic [N-1:0]      hit_bit;
    logic              hit_all;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rdata_q;
    logic              unused_wdata;

    assign unused_wdata = ^wdata_i[DATA_W-1:N];
    assign hit_all      = rd_i && (addr_i == ADDR_W'(ADR_CLR_ALL));

    for (genvar b = 0; b < N; b++) begin : g_dec
        // per-interrupt clear address match
        assign hit_bit[b] = rd_i && (addr_i == ADDR_W'(ADR_CLR_BASE + b));
    end

    assign clr_bits_o  = (hit_bit | {N{hit_all}}) & STICKY_BITS;
    assign clr_cause_o = hit_all | hit_bit[IRQ_TX_ABRT];

    // mask register, written only at its own address
    always_ff @(posedge clk) begin
        if (!rst_n)                                   mask_q <= '0;
        else if (wr_i && addr_i == ADDR_W'(ADR_MASK)) mask_q <= wdata_i[N-1:0];
    end

    // read data selection
    always_comb begin
        rd_val = '0;
        case (addr_i)
            ADDR_W'(ADR_RAW):     rd_val[N-1:0] = raw_i;
            ADDR_W'(ADR_MASK):    rd_val[N-1:0] = mask_q;
            ADDR_W'(ADR_MASKED):  rd_val[N-1:0] = raw_i & mask_q;
            ADDR_W'(ADR_CAUSE):   rd_val = DATA_W'(cause_i);
            ADDR_W'(ADR_CLR_ALL): rd_val[N-1:0] = raw_i & STICKY_BITS;
            default: begin
                for (int b = 0; b < N; b++) begin
                    if (addr_i == ADDR_W'(ADR_CLR_BASE + b))
                        rd_val[0] = raw_i[b] & STICKY_BITS[b];
                end
            end
        endcase
    end

    // read data register, loaded on each read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_val;
    end

    assign mask_o  = mask_q;
    assign rdata_o = rdata_q;

endmodule

// File: rtl/i2c_irq_agg.sv
// I2C interrupt status aggregator top. Merges event pulses, level conditions
// and abort causes into raw and masked status, drives the interrupt line and
// the transmit FIFO level flush pulse.
// Assumes all inputs are synchronous to clk.
module i2c_irq_agg
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 32,
    parameter int CAUSE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NIRQ-1:0]    evt_pulse_i,
    input  logic [1:0]         evt_level_i,
    input  logic [CAUSE_W-1:0] abrt_set_i,
    input  logic               restart_en_i,
    input  logic               tar_special_i,
    input  logic               tar_gc_start_i,
    input  logic               reg_rd_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic [NIRQ-1:0]    raw_stat_o,
    output logic [NIRQ-1:0]    masked_stat_o,
    output logic               irq_o,
    output logic               tx_flush_o
);

    logic               abort_evt;
    logic [NIRQ-1:0]    set_vec;
    logic [NIRQ-1:0]    lvl_vec;
    logic [NIRQ-1:0]    clr_bits;
    logic [NIRQ-1:0]    mask_q;
    logic [NIRQ-1:0]    raw;
    logic [CAUSE_W-1:0] cause_q;
    logic               clr_cause;
    logic               sbyte_cause;
    logic               tx_flush_q;

    assign abort_evt   = evt_pulse_i[IRQ_TX_ABRT] | (|abrt_set_i);
    assign set_vec     = evt_pulse_i | (NIRQ'(abort_evt) << IRQ_TX_ABRT);
    assign sbyte_cause = !restart_en_i && tar_special_i && tar_gc_start_i;

    // place the two level conditions at their raw positions
    always_comb begin
        lvl_vec               = '0;
        lvl_vec[IRQ_RX_FULL]  = evt_level_i[0];
        lvl_vec[IRQ_TX_EMPTY] = evt_level_i[1];
    end

    i2c_irq_status_bank #(
        .N     (NIRQ),
        .LEVEL (LEVEL_BITS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .clr_i   (clr_bits),
        .level_i (lvl_vec),
        .raw_o   (raw)
    );

    i2c_irq_abort_cause #(
        .W        (CAUSE_W),
        .HOLD_BIT (CAUSE_SBYTE_NORST)
    ) u_cause (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (abrt_set_i),
        .clr_i        (clr_cause),
        .hold_cause_i (sbyte_cause),
        .cause_o      (cause_q)
    );

    i2c_irq_host_port #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .N       (NIRQ),
        .CAUSE_W (CAUSE_W)
    ) u_host (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_i        (reg_rd_i),
        .wr_i        (reg_wr_i),
        .addr_i      (reg_addr_i),
        .wdata_i     (reg_wdata_i),
        .raw_i       (raw),
        .cause_i     (cause_q),
        .mask_o      (mask_q),
        .clr_bits_o  (clr_bits),
        .clr_cause_o (clr_cause),
        .rdata_o     (reg_rdata_o)
    );

    // flush pulse registered alongside the raw abort flag
    always_ff @(posedge clk) begin
        if (!rst_n) tx_flush_q <= 1'b0;
        else        tx_flush_q <= abort_evt;
    end

    assign raw_stat_o    = raw;
    assign masked_stat_o = raw & mask_q;
    assign irq_o         = |masked_stat_o;
    assign tx_flush_o    = tx_flush_q;

endmodule

// File: rtl/i2c_irq_agg_chk.sv
// Property checker for the interrupt aggregator, bound to the top module.
// Observes status, strobes and the abort-cause register over time.
module i2c_irq_agg_chk
    import i2c_irq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [NIRQ-1:0] raw,
    input logic [NIRQ-1:0] mask,
    input logic [NIRQ-1:0] set_bits,
    input logic [NIRQ-1:0] clr_bits,
    input logic            clr_cause,
    input logic            present,
    input logic [31:0]     abrt_set,
    input logic [31:0]     cause,
    input logic            irq,
    input logic            tx_flush
);

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(raw) & ~$past(clr_bits) & STICKY_BITS) & ~raw) == '0));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(set_bits) & STICKY_BITS) & ~raw) == '0));

    // R4
    irq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    // R7
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_bits == STICKY_BITS && (set_bits & STICKY_BITS) == '0)
        |=> ((raw & STICKY_BITS) == '0));

    // R10
    sbyte_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cause && !$past(clr_cause) && !abrt_set[CAUSE_SBYTE_NORST])
        |=> !cause[CAUSE_SBYTE_NORST]);

    // R10
    sbyte_reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_cause) && $past(present) && present)
        |=> cause[CAUSE_SBYTE_NORST]);

    // R12
    flush_on_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw[IRQ_TX_ABRT]) |-> tx_flush);

endmodule

bind i2c_irq_agg i2c_irq_agg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw       (raw_stat_o),
    .mask      (mask_q),
    .set_bits  (set_vec),
    .clr_bits  (clr_bits),
    .clr_cause (clr_cause),
    .present   (sbyte_cause),
    .abrt_set  (abrt_set_i),
    .cause     (cause_q),
    .irq       (irq_o),
    .tx_flush  (tx_flush_o)
);

// File: tb/i2c_irq_agg_test.sv
`timescale 1ns/1ps
// Directed bench for the interrupt aggregator: one task per scenario.
module i2c_irq_agg_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] evt_pulse = '0;
    logic [1:0]  evt_level = '0;
    logic [31:0] abrt_set = '0;
    logic        restart_en = 1'b0;
    logic        tar_special = 1'b0;
    logic        tar_gc_start = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [12:0] raw_stat;
    logic [12:0] masked_stat;
    logic        irq;
    logic        tx_flush;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    i2c_irq_agg uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .evt_pulse_i    (evt_pulse),
        .evt_level_i    (evt_level),
        .abrt_set_i     (abrt_set),
        .restart_en_i   (restart_en),
        .tar_special_i  (tar_special),
        .tar_gc_start_i (tar_gc_start),
        .reg_rd_i       (reg_rd),
        .reg_wr_i       (reg_wr),
        .reg_addr_i     (reg_addr),
        .reg_wdata_i    (reg_wdata),
        .reg_rdata_o    (reg_rdata),
        .raw_stat_o     (raw_stat),
        .masked_stat_o  (masked_stat),
        .irq_o          (irq),
        .tx_flush_o     (tx_flush)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_rd = 1'b1;
        reg_addr = a;
        tick();
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [12:0] e, input logic [31:0] c);
        evt_pulse = e;
        abrt_set = c;
        tick();
        evt_pulse = '0;
        abrt_set = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 raw", 32'(raw_stat), 32'h0);
        chk("R1 masked", 32'(masked_stat), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        rd(5'd1, d); chk("R1 mask", d, 32'h0);
        rd(5'd3, d); chk("R1 cause", d, 32'h0);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        pulse(13'h001, 32'h0);
        chk("R2 set", 32'(raw_stat), 32'h001);
        tick(); tick(); tick();
        chk("R2 hold", 32'(raw_stat), 32'h001);
        pulse(13'h014, 32'h0);
        chk("R3 pulse ignored", 32'(raw_stat), 32'h001);
        evt_level = 2'b01;
        #1;
        chk("R3 level", 32'(raw_stat), 32'h005);
        rd(5'd18, d);
        chk("R3 clr rdata", d, 32'h0);
        chk("R3 not cleared", 32'(raw_stat), 32'h005);
        evt_level = 2'b00;
        #1;
        chk("R3 level drop", 32'(raw_stat), 32'h001);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        chk("R4 blocked", {31'h0, irq}, 32'h0);
        wr(5'd1, 32'h0000_0001);
        chk("R4 masked", 32'(masked_stat), 32'h001);
        chk("R4 irq", {31'h0, irq}, 32'h1);
        rd(5'd1, d); chk("R13 mask read", d, 32'h1);
        rd(5'd0, d); chk("R13 raw read", d, 32'h001);
        wr(5'd1, 32'hFFFF_1FFE);
        chk("R5 raw kept", 32'(raw_stat), 32'h001);
        chk("R4 masked off", 32'(masked_stat), 32'h0);
        chk("R4 irq off", {31'h0, irq}, 32'h0);
        rd(5'd2, d); chk("R13 masked read", d, 32'h0);
    endtask

    task automatic t_clear_one();
        logic [31:0] d;
        pulse(13'h202, 32'h0);
        chk("R4 masked two", 32'(masked_stat), 32'h202);
        rd(5'd17, d);
        chk("R6 pre value", d, 32'h1);
        chk("R6 only one", 32'(raw_stat), 32'h201);
        rd(5'd17, d);
        chk("R6 second read", d, 32'h0);
    endtask

    task automatic t_set_wins();
        evt_pulse = 13'h080;
        reg_rd = 1'b1;
        reg_addr = 5'd23;
        tick();
        reg_rd = 1'b0;
        evt_pulse = '0;
        chk("R8 rdata", reg_rdata, 32'h0);
        chk("R8 raw", 32'(raw_stat), 32'h281);
    endtask

    task automatic t_abort();
        logic [31:0] d;
        pulse(13'h000, 32'h5);
        chk("R9 raw abrt", 32'(raw_stat), 32'h2C1);
        chk("R12 flush", {31'h0, tx_flush}, 32'h1);
        tick();
        chk("R12 flush end", {31'h0, tx_flush}, 32'h0);
        rd(5'd3, d); chk("R9 cause", d, 32'h5);
        rd(5'd22, d); chk("R9 clr rdata", d, 32'h1);
        chk("R9 raw clr", 32'(raw_stat), 32'h281);
        rd(5'd3, d); chk("R9 cause clr", d, 32'h0);
        pulse(13'h040, 32'h0);
        chk("R9 evt abrt", 32'(raw_stat), 32'h2C1);
        chk("R12 evt flush", {31'h0, tx_flush}, 32'h1);
        rd(5'd22, d);
    endtask

    task automatic t_clear_all();
        logic [31:0] d;
        pulse(13'h420, 32'h8);
        evt_level = 2'b10;
        #1;
        chk("R3 level two", 32'(raw_stat), 32'h6F1);
        rd(5'd4, d);
        chk("R7 rdata", d, 32'h6E1);
        chk("R7 raw", 32'(raw_stat), 32'h010);
        rd(5'd3, d);
        chk("R7 cause", d, 32'h0);
        evt_level = 2'b00;
        #1;
    endtask

    task automatic sbyte_removed(input string tag);
        logic [31:0] d;
        pulse(13'h000, 32'h200);
        rd(5'd22, d);
        rd(5'd3, d); chk({tag, " dip"}, d, 32'h0);
        rd(5'd3, d); chk({tag, " stays"}, d, 32'h0);
    endtask

    task automatic t_sbyte();
        logic [31:0] d;
        restart_en = 1'b0; tar_special = 1'b1; tar_gc_start = 1'b1;
        pulse(13'h000, 32'h200);
        rd(5'd3, d); chk("R10 set", d, 32'h200);
        rd(5'd22, d);
        rd(5'd3, d); chk("R10 dip", d, 32'h0);
        rd(5'd3, d); chk("R10 back", d, 32'h200);
        restart_en = 1'b1;
        rd(5'd4, d);
        rd(5'd3, d); chk("R11 restart dip", d, 32'h0);
        rd(5'd3, d); chk("R11 restart stays", d, 32'h0);
        restart_en = 1'b0; tar_special = 1'b0;
        sbyte_removed("R11 special");
        tar_special = 1'b1; tar_gc_start = 1'b0;
        sbyte_removed("R11 gc_start");
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_sticky();
        t_mask();
        t_clear_one();
        t_set_wins();
        t_abort();
        t_clear_all();
        t_sbyte();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule